// File: doc/BRIEF.md
# Eight-bit accumulator computer with status flags

A small stored-program machine built around an 8-bit accumulator. Its memory is an internal 256-byte array that holds both program and data. Every memory word is one byte. Every operand and every branch target is one absolute byte. The processor fetches an opcode in two timed steps and then runs a short execute sequence of timing steps chosen by the opcode. At the end of that sequence the step counter returns to its first state, and the next fetch begins.

In normal use the host writes a program into memory through a byte-wide load port while the machine is idle, then raises the start input. While the program runs, the busy output stays high. The program counter, accumulator and status flags can be watched on registered outputs. A program ends when it reaches an opcode outside the defined set. A jump opcode can take its target from an external address input. The reset input is filtered, so that a short glitch cannot wipe the machine's state.

Top module: `cpu8_core`

## Requirements
- R1: The machine reinitialises (PC, AC and all flags to 0, busy low, step counter to its first step) only on the clock edge at which reset_in has been sampled high on three consecutive edges, counting that edge. A pulse of two cycles changes nothing.
- R2: A 0-to-1 change on start_in while idle raises busy and starts fetching at address 0. A rising edge of start_in while busy is ignored.
- R3: Every instruction begins with a two-cycle fetch. In the first step the byte at PC is read. In the second step that byte becomes the opcode and PC advances by one. A program of LDIM, ADDI, NOT, INC, ADDI, STD, LDD and a halt byte keeps busy high for exactly 32 cycles.
- R4: The opcode values are INC=1, NOT=2, LDIM=3, ADDI=4, SUBIM=5, LDD=6, STD=7, BRZ=8, BRNZ=9, BRC=10, BRNC=11, BRN=12, BRP=13, BRV=14, BRNV=15, JMP=16, JEXT=17, ANDI=18, ORI=19, XORI=20, XNRI=21, NOP=22 and CMPI=23.
- R5: INC, NOT and NOP finish in one execute step. The immediate opcodes (LDIM, ADDI, SUBIM, ANDI, ORI, XORI, XNRI, CMPI) read the next byte in one step, then apply it and advance PC in the following step.
- R6: LDD uses the next byte as an address and loads the byte stored there into AC, taking four execute steps. STD writes AC to the byte at that address, taking three execute steps.
- R7: flags_out is {S, Z, V, C} from bit 3 down to bit 0. INC, ADDI, SUBIM and CMPI update all four flags. For subtraction, C is the carry out of AC plus the inverted operand plus one, so C=0 means a borrow. V is signed overflow. NOT, LDIM, LDD and the four logic opcodes update only Z and S. All other opcodes leave the flags unchanged.
- R8: CMPI sets the flags exactly as SUBIM would, but leaves AC unchanged.
- R9: The conditional branches test a single flag: BRZ takes Z=1, BRNZ takes Z=0, BRC takes C=1, BRNC takes C=0, BRN takes S=1, BRP takes S=0, BRV takes V=1 and BRNV takes V=0. JMP always branches. A taken branch loads its target byte into PC. An untaken branch steps PC past the target byte.
- R10: JEXT has no operand byte. It loads PC from ext_addr in its first execute step.
- R11: An opcode outside 1 to 23 stops execution. Busy falls after one execute step, and PC is left one past the halting byte.
- R12: A load-port write stores ld_data at ld_addr only while the machine is idle. A write attempted while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset_in | input | 1 | Reset request, acted on after three consecutive high cycles |
| start_in | input | 1 | Start request, acted on at its rising edge |
| ext_addr | input | W | Jump target used by JEXT |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | W | Load-port byte address |
| ld_data | input | W | Load-port byte value |
| busy | output | 1 | High while a program runs |
| pc_out | output | W | Program counter |
| ac_out | output | W | Accumulator |
| flags_out | output | 4 | Status flags {S, Z, V, C} |

## Verification
The bench builds the block with its default values: W=8, RST_HOLD=3 and T_COUNT=6. With W=8 the full 256-byte space is reachable, so the programs can use high data addresses (200 and 250) as well as the 0x7F-to-0x80 sign crossing that sets V. With RST_HOLD=3 the two-cycle reset pulse, one short of the threshold, can be tested directly. With T_COUNT=6 the longest sequence, the six-step direct load, fits, and its cycle count can be compared with a behavioural model on every clock.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int OPW = 8;

  typedef enum logic [OPW-1:0] {
    OP_INC   = 8'd1,  OP_NOT   = 8'd2,  OP_LDIM  = 8'd3,  OP_ADDI  = 8'd4,
    OP_SUBIM = 8'd5,  OP_LDD   = 8'd6,  OP_STD   = 8'd7,  OP_BRZ   = 8'd8,
    OP_BRNZ  = 8'd9,  OP_BRC   = 8'd10, OP_BRNC  = 8'd11, OP_BRN   = 8'd12,
    OP_BRP   = 8'd13, OP_BRV   = 8'd14, OP_BRNV  = 8'd15, OP_JMP   = 8'd16,
    OP_JEXT  = 8'd17, OP_ANDI  = 8'd18, OP_ORI   = 8'd19, OP_XORI  = 8'd20,
    OP_XNRI  = 8'd21, OP_NOP   = 8'd22, OP_CMPI  = 8'd23
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic v;
    logic c;
  } flags_t;

  // R4: defined opcode range
  function automatic logic op_known(op_e op);
    return (op >= OP_INC) && (op <= OP_CMPI);
  endfunction

  function automatic logic op_is_imm(op_e op);
    return op inside {OP_LDIM, OP_ADDI, OP_SUBIM, OP_ANDI, OP_ORI, OP_XORI, OP_XNRI, OP_CMPI};
  endfunction

  function automatic logic op_is_branch(op_e op);
    return (op >= OP_BRZ) && (op <= OP_JMP);
  endfunction

  function automatic logic op_is_short(op_e op);
    return op inside {OP_INC, OP_NOT, OP_NOP, OP_JEXT};
  endfunction
endpackage

// File: rtl/cpu8_inputs.sv
module cpu8_inputs #(
  parameter int RST_HOLD = 3
) (
  input  logic clk,
  input  logic reset_in,
  input  logic start_in,
  output logic rst_now,
  output logic start_rise,
  output logic armed
);
  localparam int CW = $clog2(RST_HOLD + 1);

  logic [CW-1:0] run_len;
  logic          start_q;

  // R1: reset only on the edge that completes RST_HOLD consecutive highs
  assign rst_now    = reset_in && (run_len == CW'(RST_HOLD - 1));
  assign start_rise = start_in && !start_q;

  always_ff @(posedge clk) begin
    if (!reset_in)    run_len <= '0;
    else if (!rst_now) run_len <= run_len + CW'(1);
    start_q <= start_in;
    if (rst_now) armed <= 1'b1;
  end
endmodule

// File: rtl/cpu8_timing.sv
module cpu8_timing #(
  parameter int T_COUNT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               clr,
  output logic [T_COUNT-1:0] t
);
  localparam int TW = $clog2(T_COUNT);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || clr)           cnt <= '0;
    else if (cnt != TW'(T_COUNT - 1)) cnt <= cnt + TW'(1);
  end

  for (genvar i = 0; i < T_COUNT; i++) begin : g_dec
    assign t[i] = (cnt == TW'(i));
  end
endmodule

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic         re,
  input  logic [W-1:0] raddr,
  output logic [W-1:0] rdata
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // registered read port doubles as the data register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output flags_t       nf,
  output logic         wr_ac,
  output logic         upd_all,
  output logic         upd_zs
);
  logic [W-1:0] addend;
  logic         cin;
  logic         arith;
  logic [W:0]   sum;

  always_comb begin
    addend  = '0;
    cin     = 1'b0;
    arith   = 1'b0;
    res     = a;
    wr_ac   = 1'b0;
    upd_all = 1'b0;
    upd_zs  = 1'b0;
    case (op)
      OP_INC:   begin arith = 1'b1; cin = 1'b1; wr_ac = 1'b1; upd_all = 1'b1; end
      OP_ADDI:  begin arith = 1'b1; addend = b; wr_ac = 1'b1; upd_all = 1'b1; end
      OP_SUBIM: begin arith = 1'b1; addend = ~b; cin = 1'b1; wr_ac = 1'b1; upd_all = 1'b1; end
      OP_CMPI:  begin arith = 1'b1; addend = ~b; cin = 1'b1; upd_all = 1'b1; end
      OP_NOT:   begin res = ~a;    wr_ac = 1'b1; upd_zs = 1'b1; end
      OP_LDIM,
      OP_LDD:   begin res = b;     wr_ac = 1'b1; upd_zs = 1'b1; end
      OP_ANDI:  begin res = a & b; wr_ac = 1'b1; upd_zs = 1'b1; end
      OP_ORI:   begin res = a | b; wr_ac = 1'b1; upd_zs = 1'b1; end
      OP_XORI:  begin res = a ^ b; wr_ac = 1'b1; upd_zs = 1'b1; end
      OP_XNRI:  begin res = ~(a ^ b); wr_ac = 1'b1; upd_zs = 1'b1; end
      default:  ;
    endcase
    sum = {1'b0, a} + {1'b0, addend} + (W+1)'(cin);
    if (arith) res = sum[W-1:0];
  end

  // R7: C is the raw carry out; V compares operand and result signs
  assign nf.s = res[W-1];
  assign nf.z = (res == '0);
  assign nf.c = sum[W];
  assign nf.v = (a[W-1] == addend[W-1]) && (res[W-1] != a[W-1]);
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int W        = 8,
  parameter int RST_HOLD = 3,
  parameter int T_COUNT  = 6
) (
  input  logic         clk,
  input  logic         reset_in,
  input  logic         start_in,
  input  logic [W-1:0] ext_addr,
  input  logic         ld_we,
  input  logic [W-1:0] ld_addr,
  input  logic [W-1:0] ld_data,
  output logic         busy,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] ac_out,
  output logic [3:0]   flags_out
);
  logic         rst_now, start_rise, armed;
  logic [T_COUNT-1:0] t;
  logic         tc_clr;
  logic [W-1:0] pc, ac, ar, ir, dr;
  flags_t       flags;
  op_e          op;
  logic         known, imm, br, lda, sta, short_op, taken;
  logic         mem_re, mem_we;
  logic [W-1:0] mem_raddr, mem_waddr, mem_wdata;
  logic [W-1:0] alu_res;
  flags_t       alu_flags;
  logic         alu_wr, alu_all, alu_zs, alu_fire;

  cpu8_inputs #(.RST_HOLD(RST_HOLD)) u_inputs (
    .clk(clk), .reset_in(reset_in), .start_in(start_in),
    .rst_now(rst_now), .start_rise(start_rise), .armed(armed)
  );

  cpu8_timing #(.T_COUNT(T_COUNT)) u_timing (
    .clk(clk), .rst(rst_now), .run(busy), .clr(tc_clr), .t(t)
  );

  cpu8_mem #(.W(W)) u_mem (
    .clk(clk), .rst(rst_now), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(dr)
  );

  cpu8_alu #(.W(W)) u_alu (
    .op(op), .a(ac), .b(dr), .res(alu_res), .nf(alu_flags),
    .wr_ac(alu_wr), .upd_all(alu_all), .upd_zs(alu_zs)
  );

  // R4: opcode decode
  assign op       = op_e'(ir[OPW-1:0]);
  assign known    = ((ir >> OPW) == '0) && op_known(op);
  assign imm      = known && op_is_imm(op);
  assign br       = known && op_is_branch(op);
  assign lda      = known && (op == OP_LDD);
  assign sta      = known && (op == OP_STD);
  assign short_op = known && op_is_short(op);

  // R9: single-flag branch conditions
  always_comb begin
    case (op)
      OP_BRZ:  taken = flags.z;
      OP_BRNZ: taken = !flags.z;
      OP_BRC:  taken = flags.c;
      OP_BRNC: taken = !flags.c;
      OP_BRN:  taken = flags.s;
      OP_BRP:  taken = !flags.s;
      OP_BRV:  taken = flags.v;
      OP_BRNV: taken = !flags.v;
      OP_JMP:  taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

  // R3, R5, R6: memory read steps
  assign mem_re    = busy && (t[0] || (t[2] && (imm || br || lda || sta)) || (t[4] && lda));
  assign mem_raddr = (t[4] && lda) ? ar : pc;
  // R12: the load port writes only while idle
  assign mem_we    = !rst_now && ((busy && t[4] && sta) || (!busy && ld_we));
  assign mem_waddr = busy ? ar : ld_addr;
  assign mem_wdata = busy ? ac : ld_data;

  assign alu_fire = busy && ((t[2] && known && (op == OP_INC || op == OP_NOT)) ||
                             (t[3] && imm) || (t[5] && lda));
  assign tc_clr   = busy && ((t[2] && (!known || short_op)) || (t[3] && (imm || br)) ||
                             (t[4] && sta) || (t[5] && lda));

  always_ff @(posedge clk) begin
    if (rst_now) begin
      pc    <= '0;
      ac    <= '0;
      ar    <= '0;
      ir    <= '0;
      flags <= '0;
      busy  <= 1'b0;
    end else if (!busy) begin
      if (start_rise) begin
        busy <= 1'b1;
        pc   <= '0;
      end
    end else begin
      if (t[1]) begin
        ir <= dr;
        pc <= pc + W'(1);
      end
      if (t[2] && known && op == OP_JEXT) pc <= ext_addr;
      if (t[2] && !known) busy <= 1'b0;
      if (t[3] && (imm || lda || sta)) pc <= pc + W'(1);
      if (t[3] && br) pc <= taken ? dr : pc + W'(1);
      if (t[3] && (lda || sta)) ar <= dr;
      if (alu_fire) begin
        if (alu_wr) ac <= alu_res;
        if (alu_all) flags <= alu_flags;
        else if (alu_zs) begin
          flags.z <= alu_flags.z;
          flags.s <= alu_flags.s;
        end
      end
    end
  end

  assign pc_out    = pc;
  assign ac_out    = ac;
  assign flags_out = flags;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!armed)
    rst_now |=> (!busy && pc == '0 && ac == '0 && flags == '0));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst_now || !armed)
    (!busy && start_rise) |=> (busy && pc == '0 && t[0]));

  // R3
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst_now || !armed)
    (busy && t[1]) |=> (pc == $past(pc) + W'(1)));

  // R7
  store_flags_chk: assert property (@(posedge clk) disable iff (rst_now || !armed)
    (busy && t[4] && sta) |=> $stable(flags));

  // R8
  cmp_keeps_ac_chk: assert property (@(posedge clk) disable iff (rst_now || !armed)
    (busy && t[3] && known && op == OP_CMPI) |=> (ac == $past(ac)));

  // R9
  branch_skip_chk: assert property (@(posedge clk) disable iff (rst_now || !armed)
    (busy && t[3] && br && !taken) |=> (pc == $past(pc) + W'(1)));

  // R11
  halt_chk: assert property (@(posedge clk) disable iff (rst_now || !armed)
    (busy && t[2] && !known) |=> !busy);
endmodule

// File: tb/cpu8_core_tb.sv
module cpu8_core_tb;
  localparam int CLK_P    = 10;
  localparam int RST_HOLD = 3;
  localparam int WD_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       reset_in = 1'b0, start_in = 1'b0, ld_we = 1'b0;
  logic [7:0] ext_addr = 8'd0, ld_addr = 8'd0, ld_data = 8'd0;
  logic       busy;
  logic [7:0] pc_out, ac_out;
  logic [3:0] flags_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  cpu8_core u_dut (
    .clk(clk), .reset_in(reset_in), .start_in(start_in), .ext_addr(ext_addr),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .busy(busy), .pc_out(pc_out), .ac_out(ac_out), .flags_out(flags_out)
  );

  always #(CLK_P/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0] mmem [256];
  logic [7:0] m_pc, m_ac, m_ar, m_dr, m_ir;
  bit ms, mz, mv, mc, m_busy, m_armed, sprev;
  int m_t = 0, rrun = 0;

  task automatic m_arith(input logic [7:0] a, input logic [7:0] b, input bit sub, input bit wr);
    int ua, ub, r, sa, sb, sr;
    ua = a; ub = b; sa = $signed(a); sb = $signed(b);
    if (sub) begin r = ua - ub; sr = sa - sb; mc = (ua >= ub); end
    else     begin r = ua + ub; sr = sa + sb; mc = (r > 255); end
    mv = (sr > 127) || (sr < -128);
    r = r & 255;
    mz = (r == 0); ms = (r >= 128);
    if (wr) m_ac = r[7:0];
  endtask

  task automatic m_zs(input logic [7:0] r);
    m_ac = r; mz = (r == 0); ms = r[7];
  endtask

  task automatic m_exec();
    bit fin = 1'b0;
    int o = m_ir;
    if (o == 1 || o == 2 || o == 22 || o == 17) begin
      if (o == 1) m_arith(m_ac, 8'd1, 1'b0, 1'b1);
      if (o == 2) m_zs(~m_ac);
      if (o == 17) m_pc = ext_addr;
      fin = 1'b1;
    end else if (o == 3 || o == 4 || o == 5 || (o >= 18 && o <= 21) || o == 23) begin
      if (m_t == 2) m_dr = mmem[m_pc];
      else begin
        case (o)
          3: m_zs(m_dr);
          4: m_arith(m_ac, m_dr, 1'b0, 1'b1);
          5: m_arith(m_ac, m_dr, 1'b1, 1'b1);
          18: m_zs(m_ac & m_dr);
          19: m_zs(m_ac | m_dr);
          20: m_zs(m_ac ^ m_dr);
          21: m_zs(~(m_ac ^ m_dr));
          default: m_arith(m_ac, m_dr, 1'b1, 1'b0);
        endcase
        m_pc = m_pc + 8'd1; fin = 1'b1;
      end
    end else if (o == 6 || o == 7) begin
      case (m_t)
        2: m_dr = mmem[m_pc];
        3: begin m_ar = m_dr; m_pc = m_pc + 8'd1; end
        4: if (o == 6) m_dr = mmem[m_ar];
           else begin mmem[m_ar] = m_ac; fin = 1'b1; end
        default: begin m_zs(m_dr); fin = 1'b1; end
      endcase
    end else if (o >= 8 && o <= 16) begin
      if (m_t == 2) m_dr = mmem[m_pc];
      else begin
        bit tk;
        case (o)
          8: tk = mz;   9: tk = !mz;  10: tk = mc;  11: tk = !mc;
          12: tk = ms;  13: tk = !ms; 14: tk = mv;  15: tk = !mv;
          default: tk = 1'b1;
        endcase
        m_pc = tk ? m_dr : m_pc + 8'd1; fin = 1'b1;
      end
    end else begin
      m_busy = 1'b0; fin = 1'b1;
    end
    m_t = fin ? 0 : m_t + 1;
  endtask

  always @(posedge clk) begin
    bit rhit, srise;
    rhit  = reset_in && (rrun >= RST_HOLD - 1);
    rrun  = reset_in ? rrun + 1 : 0;
    srise = start_in && !sprev;
    sprev = start_in;
    if (rhit) begin
      m_pc = 0; m_ac = 0; m_ar = 0; {ms, mz, mv, mc} = 4'b0; m_busy = 0; m_t = 0; m_armed = 1;
    end else if (!m_busy) begin
      if (ld_we) mmem[ld_addr] = ld_data;
      if (srise) begin m_busy = 1; m_pc = 0; m_t = 0; end
    end else if (m_t == 0) begin
      m_dr = mmem[m_pc]; m_t = 1;
    end else if (m_t == 1) begin
      m_ir = m_dr; m_pc = m_pc + 8'd1; m_t = 2;
    end else m_exec();
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_armed && !done) begin
      checks++;
      if (busy !== m_busy || pc_out !== m_pc || ac_out !== m_ac || flags_out !== {ms, mz, mv, mc}) begin
        errors++;
        if (busy !== m_busy) $display("FAIL R2/R11 busy cycle %0d actual %0d expected %0d", cyc, busy, m_busy);
        if (pc_out !== m_pc) $display("FAIL R9/R10 pc cycle %0d actual %0d expected %0d", cyc, pc_out, m_pc);
        if (ac_out !== m_ac) $display("FAIL R5/R8 ac cycle %0d actual %0d expected %0d", cyc, ac_out, m_ac);
        if (flags_out !== {ms, mz, mv, mc})
          $display("FAIL R7 flags cycle %0d actual %0d expected %0d", cyc, flags_out, {ms, mz, mv, mc});
      end
    end
  end

  bit p1_on = 0, p2_on = 0, saw_skip = 0, saw_ext = 0, got22 = 0;
  int busy_cnt = 0;
  logic [7:0] ac_at22;
  always @(negedge clk) begin
    if (p1_on && busy) busy_cnt++;
    if (p2_on && busy) begin
      if (pc_out == 8'd5) saw_skip = 1;
      if (pc_out == 8'd50) saw_ext = 1;
      if (pc_out == 8'd22 && !got22) begin got22 = 1; ac_at22 = ac_out; end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      errors++;
      $display("FAIL R3 watchdog actual %0d expected below %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic put(input logic [7:0] a, input logic [7:0] d);
    ld_we = 1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 0;
  endtask

  task automatic pulse_reset(input int n);
    reset_in = 1;
    repeat (n) @(negedge clk);
    reset_in = 0;
    @(negedge clk);
  endtask

  task automatic run_prog();
    start_in = 1;
    @(negedge clk);
    start_in = 0;
    while (busy) @(negedge clk);
  endtask

  logic [7:0] p1 [13] = '{3, 52, 4, 25, 2, 1, 4, 83, 7, 250, 6, 250, 0};
  logic [7:0] p2 [60] = '{
    3, 8'h7F, 1, 14, 7, 0, 0, 15, 0, 5, 8'h80, 9, 0, 8, 16, 0, 3, 5, 23, 9,
    10, 0, 11, 25, 0, 20, 8'h0F, 21, 8'hF0, 18, 4, 19, 8'h80, 13, 0, 12, 38, 0, 22, 16,
    42, 0, 17, 0, 0, 0, 0, 0, 0, 0, 2, 4, 5, 7, 200, 3, 0, 6, 200, 255};

  initial begin
    for (int i = 0; i < 256; i++) mmem[i] = 8'd0;
    repeat (2) @(negedge clk);
    pulse_reset(3);
    // R1 reset state
    chk(pc_out == 0, "R1 pc after reset", pc_out, 0);
    chk(ac_out == 0, "R1 ac after reset", ac_out, 0);
    chk(flags_out == 0, "R1 flags after reset", flags_out, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);

    for (int i = 0; i < 64; i++) put(i[7:0], 8'd0);
    for (int i = 0; i < 13; i++) put(i[7:0], p1[i]);
    p1_on = 1;
    run_prog();
    p1_on = 0;
    // R3 fetch plus execute cycle total
    chk(busy_cnt == 32, "R3 busy cycles program one", busy_cnt, 32);
    // R6 store then direct load gives 83-(52+25)
    chk(ac_out == 8'd6, "R6 ac program one", ac_out, 6);
    // R7 ADDI carry out, Z S clear
    chk(flags_out == 4'b0001, "R7 flags program one", flags_out, 1);
    // R11 halt leaves pc past the halting byte
    chk(pc_out == 8'd13, "R11 pc after halt", pc_out, 13);

    pulse_reset(2);
    // R1 two-cycle pulse ignored
    chk(ac_out == 8'd6, "R1 short reset keeps ac", ac_out, 6);
    chk(pc_out == 8'd13, "R1 short reset keeps pc", pc_out, 13);
    pulse_reset(3);
    chk(ac_out == 0 && flags_out == 0, "R1 full reset clears ac/flags", {ac_out, flags_out}, 0);

    for (int i = 0; i < 60; i++) put(i[7:0], p2[i]);
    ext_addr = 8'd50;
    p2_on = 1;
    start_in = 1;
    @(negedge clk);
    start_in = 0;
    repeat (10) @(negedge clk);
    put(8'd59, 8'd22);      // R12 write while busy must be dropped
    repeat (5) @(negedge clk);
    start_in = 1;           // R2 start edge while busy ignored
    @(negedge clk);
    start_in = 0;
    while (busy) @(negedge clk);
    p2_on = 0;
    // R12 halt byte untouched, so halt at 59
    chk(pc_out == 8'd60, "R12 pc after program two", pc_out, 60);
    // R6 direct load of stored 0x80
    chk(ac_out == 8'h80, "R6 ac program two", ac_out, 8'h80);
    // R7 final flags S=1 Z=0 V=1 C=0
    chk(flags_out == 4'b1010, "R7 flags program two", flags_out, 4'b1010);
    // R9 taken BRV skipped address 5
    chk(!saw_skip, "R9 taken branch skipped bytes", saw_skip, 0);
    // R10 JEXT reached ext_addr
    chk(saw_ext, "R10 external jump target", saw_ext, 1);
    // R8 CMPI left AC at 5
    chk(got22 && ac_at22 == 8'd5, "R8 ac after compare", ac_at22, 5);
    // R4 R5 exercised by every cycle comparison above
    chk(busy == 0, "R11 busy low after halt", busy, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule